// File: doc/BRIEF.md
# Transactional Write Buffer Cache

A small, fully associative buffer that sits next to a processor's regular data cache and holds every line touched inside a hardware transaction. Transactional loads bring a line in and mark it as read. Transactional stores update a buffered copy and mark it as written. Written data stays private: a snoop that reaches a written line sees no hit and no data. When the processor issues commit, every transactional mark is cleared in a single cycle, and written lines become ordinary lines that answer snoops. When it issues abort, every written line is dropped and read marks are cleared.

Conflicts are found through the coherence snoops that arrive from the bus. A snoop that would break the transaction's isolation sets a sticky conflict flag. Commit succeeds only while that flag is clear. Otherwise it behaves as an abort and reports failure. Validate reports the flag without changing anything. If a miss finds every entry already holding transactional state, the block raises an overflow status and forces an abort. Whenever a line is allocated here, the block asks the regular cache to drop its copy, so a line is never held in both places.

Top module: `txbuf_cache`

## Requirements
- R1: After reset, no entry is valid, the conflict and overflow flags are clear, and rsp_valid, snp_rsp_valid, evict_req and tx_overflow are 0.
- R2: A transactional load that misses allocates an entry, returns cmd_wdata as the fill data, and pulses evict_req with evict_addr set to cmd_addr. A load that hits returns the buffered data, marks the line read and does not pulse evict_req.
- R3: A snoop that hits a transactionally written line reports snp_hit 0 and snp_data 0.
- R4: The sticky conflict flag is set, and snp_conflict is 1 in the result cycle, in two cases: an exclusive snoop (snp_excl 1) that hits a line that is read or written, or a read snoop that hits a written line. Only commit or abort clears the flag.
- R5: A read snoop that hits a valid line that is not written reports snp_hit 1 and that line's data, with no conflict.
- R6: A commit issued while the conflict flag is clear returns rsp_ok 1 and turns every written line into a normal line, which a later snoop sees with its data.
- R7: A commit issued while the conflict flag is set returns rsp_ok 0, invalidates every written line, and clears the flag.
- R8: Abort returns rsp_ok 1, invalidates every written line, keeps lines that were only read as valid normal lines, and clears the conflict and overflow flags.
- R9: Validate returns rsp_ok equal to the inverse of the conflict flag and changes no state.
- R10: A load, load-exclusive or store that misses while every valid entry is read or written returns rsp_ok 0, sets tx_overflow and the conflict flag, and performs the abort action. Commit or abort clears tx_overflow.
- R11: On a miss, the lowest-numbered invalid entry is filled. If there is none, the lowest-numbered normal entry (valid, neither read nor written) is replaced.
- R12: An exclusive snoop that hits a normal line reports it with its data and then invalidates it.
- R13: Every command with cmd_op other than 0 produces rsp_valid one cycle later. Every snoop produces snp_rsp_valid one cycle later. The cmd_op encoding is 1 load, 2 load-exclusive, 3 store, 4 commit, 5 validate, 6 abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 32 | Line address for load and store |
| cmd_wdata | input | 32 | Store data, or fill data on a load miss |
| rsp_valid | output | 1 | Command response |
| rsp_ok | output | 1 | Command success / validate result |
| rsp_data | output | 32 | Load result |
| tx_overflow | output | 1 | Sticky overflow status |
| evict_req | output | 1 | Request to the regular cache to drop a line |
| evict_addr | output | 32 | Address to drop |
| snp_valid | input | 1 | Snoop present |
| snp_excl | input | 1 | Snoop is read-exclusive |
| snp_addr | input | 32 | Snoop line address |
| snp_rsp_valid | output | 1 | Snoop result |
| snp_hit | output | 1 | Snoop may take the line's data |
| snp_data | output | 32 | Line data for the snoop |
| snp_conflict | output | 1 | Snoop conflicts with the transaction |

## Verification
The assertions assume that cmd_op never carries the unused code 7. They also assume that the processor never presents a command in the same cycle as a bus snoop, so the snoop side and the command side never update the same entry in one cycle. The random stimulus draws each cycle's action as either one command or one snoop, never both, and uses only the six defined codes. It draws addresses from a pool of twelve lines, so misses that overflow the eight entries, replacements of normal lines and snoop conflicts all occur often alongside the directed cases.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LOAD     = 3'd1,
    OP_LOADX    = 3'd2,
    OP_STORE    = 3'd3,
    OP_COMMIT   = 3'd4,
    OP_VALIDATE = 3'd5,
    OP_ABORT    = 3'd6
  } txop_e;
endpackage

// File: rtl/txbuf_match.sv
// Parallel tag compare over all entries, with index encode.
module txbuf_match #(
  parameter int N  = 8,
  parameter int AW = 32
) (
  input  logic [N-1:0][AW-1:0]          tags,
  input  logic [N-1:0]                  valid,
  input  logic [AW-1:0]                 addr,
  output logic [N-1:0]                  hit_vec,
  output logic                          hit,
  output logic [((N>1)?$clog2(N):1)-1:0] hit_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == addr);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end
endmodule

// File: rtl/txbuf_alloc.sv
// Victim choice: lowest invalid entry, else lowest normal entry.
module txbuf_alloc #(
  parameter int N = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N-1:0]                  valid,
  input  logic [N-1:0]                  rd_mark,
  input  logic [N-1:0]                  wr_mark,
  output logic [N-1:0]                  pick_vec,
  output logic                          found,
  output logic [((N>1)?$clog2(N):1)-1:0] pick_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] free_vec;
  logic [N-1:0] norm_vec;
  logic [N-1:0] cand;

  assign free_vec = ~valid;
  assign norm_vec = valid & ~rd_mark & ~wr_mark;
  assign cand     = (|free_vec) ? free_vec : norm_vec;
  assign pick_vec = cand & (~cand + N'(1));
  assign found    = |cand;

  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) pick_idx = IW'(i);
    end
  end

  // R11
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec) && (found == (pick_vec != '0)));
endmodule

// File: rtl/txbuf_cache.sv
module txbuf_cache
  import txbuf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [DW-1:0] rsp_data,
  output logic          tx_overflow,
  output logic          evict_req,
  output logic [AW-1:0] evict_addr,
  input  logic          snp_valid,
  input  logic          snp_excl,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_rsp_valid,
  output logic          snp_hit,
  output logic [DW-1:0] snp_data,
  output logic          snp_conflict
);
  localparam int N  = ENTRIES;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][AW-1:0] tag_q;
  logic [N-1:0][DW-1:0] data_q;
  logic [N-1:0] v_q, tr_q, tw_q;
  logic [N-1:0] v_d, tr_d, tw_d, ent_we;
  logic conf_q, conf_d, ovf_q, ovf_d;

  logic          rsp_valid_d, rsp_ok_d, ev_d, snp_hit_d, snp_conf_d;
  logic [DW-1:0] rsp_data_d, snp_data_d;
  logic [AW-1:0] eva_d;

  txop_e op;
  assign op = txop_e'(cmd_op);

  logic [N-1:0]  c_hitv, s_hitv, a_vec;
  logic          c_hit, s_hit_any, a_found;
  logic [IW-1:0] c_idx, s_idx, a_idx;

  txbuf_match #(.N(N), .AW(AW)) u_cmd_match (
    .tags(tag_q), .valid(v_q), .addr(cmd_addr),
    .hit_vec(c_hitv), .hit(c_hit), .hit_idx(c_idx));

  txbuf_match #(.N(N), .AW(AW)) u_snp_match (
    .tags(tag_q), .valid(v_q), .addr(snp_addr),
    .hit_vec(s_hitv), .hit(s_hit_any), .hit_idx(s_idx));

  txbuf_alloc #(.N(N)) u_alloc (
    .clk(clk), .rst_n(rst_n), .valid(v_q), .rd_mark(tr_q), .wr_mark(tw_q),
    .pick_vec(a_vec), .found(a_found), .pick_idx(a_idx));

  logic snp_conf_now, conf_eff, is_access;

  assign snp_conf_now = snp_valid && (snp_excl ? |(s_hitv & (tr_q | tw_q))
                                               : |(s_hitv & tw_q));
  assign conf_eff  = conf_q | snp_conf_now;
  assign is_access = cmd_valid && (op == OP_LOAD || op == OP_LOADX || op == OP_STORE);

  // Next-state logic
  always_comb begin
    v_d = v_q;  tr_d = tr_q;  tw_d = tw_q;
    conf_d = conf_q;  ovf_d = ovf_q;
    ent_we = '0;
    rsp_valid_d = 1'b0;  rsp_ok_d = 1'b0;  rsp_data_d = '0;
    ev_d = 1'b0;  eva_d = '0;

    // snoop side
    snp_hit_d  = snp_valid && s_hit_any && !tw_q[s_idx];
    snp_data_d = snp_hit_d ? data_q[s_idx] : '0;
    snp_conf_d = snp_conf_now;
    if (snp_valid && snp_excl) v_d = v_d & ~(s_hitv & ~tr_q & ~tw_q);
    if (snp_conf_now) conf_d = 1'b1;

    // command side
    if (cmd_valid && op != OP_NOP) begin
      rsp_valid_d = 1'b1;
      unique case (op)
        OP_LOAD, OP_LOADX, OP_STORE: begin
          rsp_ok_d = 1'b1;
          if (c_hit) begin
            v_d[c_idx] = 1'b1;
            if (op == OP_STORE) begin
              tw_d[c_idx]   = 1'b1;
              ent_we[c_idx] = 1'b1;
              rsp_data_d    = cmd_wdata;
            end else begin
              tr_d[c_idx] = 1'b1;
              rsp_data_d  = data_q[c_idx];
            end
          end else if (a_found) begin
            v_d[a_idx]    = 1'b1;
            tr_d[a_idx]   = (op != OP_STORE);
            tw_d[a_idx]   = (op == OP_STORE);
            ent_we[a_idx] = 1'b1;
            rsp_data_d    = cmd_wdata;
            ev_d          = 1'b1;
            eva_d         = cmd_addr;
          end else begin
            rsp_ok_d = 1'b0;
            v_d      = v_d & ~tw_q;
            tr_d     = '0;
            tw_d     = '0;
            ovf_d    = 1'b1;
            conf_d   = 1'b1;
          end
        end
        OP_COMMIT: begin
          rsp_ok_d = !conf_eff;
          if (conf_eff) v_d = v_d & ~tw_q;
          tr_d = '0;  tw_d = '0;
          conf_d = 1'b0;  ovf_d = 1'b0;
        end
        OP_VALIDATE: rsp_ok_d = !conf_eff;
        OP_ABORT: begin
          rsp_ok_d = 1'b1;
          v_d  = v_d & ~tw_q;
          tr_d = '0;  tw_d = '0;
          conf_d = 1'b0;  ovf_d = 1'b0;
        end
        default: rsp_ok_d = 1'b0;
      endcase
    end
  end

  // Control state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;  tr_q <= '0;  tw_q <= '0;
      conf_q <= 1'b0;  ovf_q <= 1'b0;
      rsp_valid <= 1'b0;  rsp_ok <= 1'b0;  rsp_data <= '0;
      evict_req <= 1'b0;  evict_addr <= '0;
      snp_rsp_valid <= 1'b0;  snp_hit <= 1'b0;  snp_data <= '0;
      snp_conflict <= 1'b0;
    end else begin
      v_q <= v_d;  tr_q <= tr_d;  tw_q <= tw_d;
      conf_q <= conf_d;  ovf_q <= ovf_d;
      rsp_valid <= rsp_valid_d;  rsp_ok <= rsp_ok_d;  rsp_data <= rsp_data_d;
      evict_req <= ev_d;  evict_addr <= eva_d;
      snp_rsp_valid <= snp_valid;  snp_hit <= snp_hit_d;  snp_data <= snp_data_d;
      snp_conflict <= snp_conf_d;
    end
  end

  // Tag and data storage, written only under enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (ent_we[i]) begin
        tag_q[i]  <= cmd_addr;
        data_q[i] <= cmd_wdata;
      end
    end
  end

  assign tx_overflow = ovf_q;

  // R13
  cmd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'd0) |=> rsp_valid);
  // R13
  snp_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_rsp_valid);
  // R3
  hide_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && |(s_hitv & tw_q)) |=> (!snp_hit && snp_data == '0));
  // R4
  conf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_q && !(cmd_valid && (op == OP_COMMIT || op == OP_ABORT))) |=> conf_q);
  // R10
  ovf_implies_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> conf_q);
  // R6
  end_clears_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (op == OP_COMMIT || op == OP_ABORT) && !snp_valid)
      |=> (tr_q == '0 && tw_q == '0 && !conf_q));
  // R9
  validate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_VALIDATE) |=> (rsp_ok == !$past(conf_eff)));
  // R2
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_access && c_hit) |=> !evict_req);
endmodule

// File: tb/txbuf_cache_test.sv
`timescale 1ns/1ps
module txbuf_cache_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        snp_valid = 1'b0, snp_excl = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        rsp_valid, rsp_ok, tx_overflow, evict_req;
  logic [31:0] rsp_data, evict_addr, snp_data;
  logic        snp_rsp_valid, snp_hit, snp_conflict;

  txbuf_cache uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_data(rsp_data), .tx_overflow(tx_overflow),
    .evict_req(evict_req), .evict_addr(evict_addr), .snp_valid(snp_valid),
    .snp_excl(snp_excl), .snp_addr(snp_addr), .snp_rsp_valid(snp_rsp_valid),
    .snp_hit(snp_hit), .snp_data(snp_data), .snp_conflict(snp_conflict));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  // reference model
  bit          mv[N], mtr[N], mtw[N];
  logic [31:0] mtag[N], mdat[N];
  bit          mconf, movf;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int mfind(logic [31:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == a) return i;
    return -1;
  endfunction

  function automatic int mpick();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    for (int i = 0; i < N; i++) if (!mtr[i] && !mtw[i]) return i;
    return -1;
  endfunction

  function automatic void mabort();
    for (int i = 0; i < N; i++) begin
      if (mtw[i]) mv[i] = 0;
      mtr[i] = 0; mtw[i] = 0;
    end
  endfunction

  task automatic do_cmd(int op, logic [31:0] a, logic [31:0] wd);
    int h, p; bit eok, eev; logic [31:0] edat; string rq;
    h = mfind(a); eok = 0; eev = 0; edat = 0;
    rq = (op == 4) ? (mconf ? "R7" : "R6") : (op == 5) ? "R9" : (op == 6) ? "R8" : "R10";
    case (op)
      1, 2, 3: begin
        eok = 1;
        if (h >= 0) begin
          if (op == 3) begin mdat[h] = wd; mtw[h] = 1; edat = wd; end
          else begin mtr[h] = 1; edat = mdat[h]; end
        end else begin
          p = mpick();
          if (p >= 0) begin
            mv[p] = 1; mtr[p] = (op != 3); mtw[p] = (op == 3);
            mtag[p] = a; mdat[p] = wd; edat = wd; eev = 1;
          end else begin
            eok = 0; mabort(); movf = 1; mconf = 1;
          end
        end
      end
      4: begin
        eok = !mconf;
        if (mconf) mabort();
        for (int i = 0; i < N; i++) begin mtr[i] = 0; mtw[i] = 0; end
        mconf = 0; movf = 0;
      end
      5: eok = !mconf;
      default: begin eok = 1; mabort(); mconf = 0; movf = 0; end
    endcase
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    chk("R13 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rq, {31'd0, rsp_ok}, {31'd0, eok});
    if (op <= 2) chk("R2 data", rsp_data, edat);
    chk("R2 evict_req", {31'd0, evict_req}, {31'd0, eev});
    if (eev) chk("R2 evict_addr", evict_addr, a);
    chk("R10 overflow", {31'd0, tx_overflow}, {31'd0, movf});
  endtask

  task automatic do_snp(bit ex, logic [31:0] a);
    int h; bit eh, ec; logic [31:0] ed;
    h = mfind(a);
    eh = (h >= 0) && !mtw[h];
    ed = eh ? mdat[h] : 32'd0;
    ec = (h >= 0) && (ex ? (mtr[h] || mtw[h]) : mtw[h]);
    if (ec) mconf = 1;
    if (ex && h >= 0 && !mtr[h] && !mtw[h]) mv[h] = 0;
    snp_valid = 1; snp_excl = ex; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk("R13 snp_rsp_valid", {31'd0, snp_rsp_valid}, 32'd1);
    chk(h >= 0 && mtw[h] ? "R3 hit" : "R5 hit", {31'd0, snp_hit}, {31'd0, eh});
    chk("R5 data", snp_data, ed);
    chk("R4 conflict", {31'd0, snp_conflict}, {31'd0, ec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mtr[i] = 0; mtw[i] = 0; end
    mconf = 0; movf = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R1 snp_rsp_valid", {31'd0, snp_rsp_valid}, 0);
    chk("R1 evict_req", {31'd0, evict_req}, 0);
    chk("R1 tx_overflow", {31'd0, tx_overflow}, 0);
    rst_n = 1;
    @(negedge clk);
    do_cmd(5, 0, 0);                         // R1 flag clear: validate ok
    do_snp(0, 32'h40);                       // R1 empty: miss
    // R2 miss then hit
    do_cmd(1, 32'h40, 32'hAAAA0001);
    do_cmd(1, 32'h40, 32'h0);
    // R3 / R4 / R9 / R7
    do_cmd(3, 32'h44, 32'hBBBB0002);
    do_snp(0, 32'h44);
    do_cmd(5, 0, 0);
    do_cmd(4, 0, 0);
    do_snp(0, 32'h44);                       // R7 written line dropped
    do_cmd(5, 0, 0);                         // R7 flag cleared
    do_snp(0, 32'h40);                       // R8/R5 read-only line kept
    // R6 commit publishes
    do_cmd(3, 32'h48, 32'hCCCC0003);
    do_cmd(4, 0, 0);
    do_snp(0, 32'h48);
    chk("R6 published", snp_data, 32'hCCCC0003);
    // R5 read snoop on read line, R4 exclusive on read line, R8 abort
    do_cmd(1, 32'h4C, 32'hDDDD0004);
    do_snp(0, 32'h4C);
    do_snp(1, 32'h4C);
    do_cmd(6, 0, 0);
    // R12 exclusive snoop invalidates a normal line
    do_snp(1, 32'h48);
    chk("R12 hit", {31'd0, snp_hit}, 1);
    do_snp(0, 32'h48);
    chk("R12 gone", {31'd0, snp_hit}, 0);
    // R10 overflow, R11 victim choice
    for (int k = 0; k < N; k++) do_cmd(1, 32'h200 + 32'(k*4), 32'h1000 + 32'(k));
    do_cmd(1, 32'h300, 32'h5);
    chk("R10 ovf", {31'd0, tx_overflow}, 1);
    do_cmd(5, 0, 0);
    do_cmd(4, 0, 0);
    do_cmd(3, 32'h304, 32'h6);               // R11 replaces lowest normal
    do_cmd(6, 0, 0);
    // constrained random phase
    for (int n = 0; n < 1500; n++) begin
      int r; logic [31:0] a;
      r = $urandom_range(0, 19);
      a = 32'h100 + 32'($urandom_range(0, 11) * 4);
      if (r < 6)       do_cmd(1, a, $urandom);
      else if (r < 8)  do_cmd(2, a, $urandom);
      else if (r < 12) do_cmd(3, a, $urandom);
      else if (r == 12) do_cmd(4, 0, 0);
      else if (r == 13) do_cmd(5, 0, 0);
      else if (r == 14) do_cmd(6, 0, 0);
      else             do_snp(r[0], a);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule